// File: doc/BRIEF.md
# Prescaled Coincidence Trigger Unit

This block builds an event trigger from six discriminated detector signals: a cosmic flag, a periodic clock trigger, three scintillator planes (S0, S1, S2M) and a Cherenkov counter. Each signal is first brought into the clock domain and then widened into a gate whose length the host sets in clock cycles. Nine trigger sources are derived from these gates. Two are the clock and cosmic gates taken singly. One is S2M without Cherenkov. The other six are pairwise coincidences.

Every source feeds its own prescaler. A 4-bit log-coded setting either switches the source off, passes every onset, or passes one onset in a power of two. The OR of all prescaler pulses and a software trigger input forms the event trigger. On the cycle the trigger asserts, a 17-bit pattern word is captured. Its low six bits show which input gates were open. Its upper bits show which sources fired. The captured word is held, and further triggers are blocked, until the host acknowledges it.

Configuration uses a plain write port. Addresses 0 to 8 take the prescale code of the channel with that index. Address 9 takes the gate length. No other address has any effect.

Top module: `coinc_trigger`

## Requirements
- R1: Each input passes through two synchronising flops, and its rising edge then opens a gate for exactly gate-length cycles. A new edge reloads the gate. A gate length of 0 never opens the gate. The first pattern bit can show the input 3 clock edges after it is driven.
- R2: Channel sources by index: 0 clock gate (input bit 1), 1 cosmic gate (input bit 0), 2 S2M and not Cherenkov, 3 S0·S1, 4 S0·S2M, 5 S0·Cherenkov, 6 S1·S2M, 7 S1·Cherenkov, 8 S2M·Cherenkov. A coincidence is the AND of the gates.
- R3: Prescale code 0 switches a channel off, so its source never produces a trigger.
- R4: Code 1 produces one trigger pulse for every rising edge of the channel's source.
- R5: A code n from 2 to 15 produces one pulse per 2^(n-1) source onsets, on the 2^(n-1)-th onset after the count was last cleared.
- R6: Writing a channel's code clears that channel's onset count.
- R7: The event trigger is the OR of the prescaler pulses and sw_trig. trig_out is high for one cycle, and pat_valid rises in the same cycle that pat_word is captured.
- R8: pat_word bits 5:0 are the input gate states when the word is captured: bit 0 cosmic, 1 clock trigger, 2 S0, 3 S1, 4 S2M, 5 Cherenkov.
- R9: Upper pat_word bits give the sources that fired: 6 ch2, 7 and 8 both ch8, 9 ch7, 10 ch6, 11 ch5, 12 ch4, 13 ch3, 14 sw_trig, 15 ch1, 16 ch0.
- R10: While pat_valid is high, the trigger is blocked and pat_word holds. A one-cycle pat_clr drops pat_valid. Prescaler counts keep advancing while the trigger is blocked, and pulses that occur then are lost.
- R11: After reset, trig_out and pat_valid are 0, pat_word is 0, every prescale code is 0, and the gate length is GATE_RST.
- R12: Writes to addresses 10 to 15 change no channel code and no gate length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_in | input | 6 | Asynchronous detector inputs (bit map as R8) |
| sw_trig | input | 1 | Synchronous software trigger |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (4) | Write address: 0-8 prescale codes, 9 gate length |
| cfg_wdata | input | DATA_W (8) | Write data; code in bits 3:0 |
| pat_clr | input | 1 | Acknowledge of the captured pattern |
| trig_out | output | 1 | One-cycle event trigger |
| pat_valid | output | 1 | Captured pattern is held |
| pat_word | output | 17 | Captured trigger pattern |

## Verification
The bench builds the block with its default parameters: an 8-bit gate length that resets to 4, and 4-bit codes, which allow dividers of up to 16384. Gate lengths of 0, 3 and 4 make the overlap and no-overlap cases of two staggered pulses reachable within a few cycles. Codes 2 and 3 give short dividers, so wrap-around, count clearing on a write, and counting while the trigger is blocked all show up in a handful of pulses. The reference model tracks the synchroniser, gate, onset and count state of every channel, and the bench compares it with the outputs every cycle.

// File: rtl/ctrg_pkg.sv
package ctrg_pkg;
  localparam int N_IN   = 6;
  localparam int N_PS   = 9;
  localparam int PAT_W  = 17;
  localparam int CODE_W = 4;
  localparam int PCNT_W = (1 << CODE_W) - 2;

  // input bit positions
  localparam int IN_COS = 0;
  localparam int IN_CLK = 1;
  localparam int IN_S0  = 2;
  localparam int IN_S1  = 3;
  localparam int IN_S2M = 4;
  localparam int IN_CER = 5;

  // terminal count for a log-coded divider: 2^(code-1)-1, zero when off
  function automatic logic [PCNT_W-1:0] ps_limit(input logic [CODE_W-1:0] code);
    logic [PCNT_W-1:0] lim;
    lim = '0;
    for (int b = 0; b < PCNT_W; b++)
      if (b < int'(code) - 1) lim[b] = 1'b1;
    return lim;
  endfunction

  function automatic logic [N_PS-1:0] coin_map(input logic [N_IN-1:0] g);
    logic [N_PS-1:0] c;
    c[0] = g[IN_CLK];
    c[1] = g[IN_COS];
    c[2] = g[IN_S2M] & ~g[IN_CER];
    c[3] = g[IN_S0]  & g[IN_S1];
    c[4] = g[IN_S0]  & g[IN_S2M];
    c[5] = g[IN_S0]  & g[IN_CER];
    c[6] = g[IN_S1]  & g[IN_S2M];
    c[7] = g[IN_S1]  & g[IN_CER];
    c[8] = g[IN_S2M] & g[IN_CER];
    return c;
  endfunction

  function automatic logic [PAT_W-1:0] pack_pattern(input logic [N_IN-1:0] g,
                                                    input logic [N_PS-1:0] hit,
                                                    input logic sw);
    logic [PAT_W-1:0] p;
    p[N_IN-1:0] = g;
    p[6]  = hit[2];
    p[7]  = hit[8];
    p[8]  = hit[8];
    p[9]  = hit[7];
    p[10] = hit[6];
    p[11] = hit[5];
    p[12] = hit[4];
    p[13] = hit[3];
    p[14] = sw;
    p[15] = hit[1];
    p[16] = hit[0];
    return p;
  endfunction
endpackage

// File: rtl/ctrg_stretch.sv
module ctrg_stretch #(
  parameter int GATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw,
  input  logic [GATE_W-1:0] len,
  output logic              gate
);
  logic [2:0]        sy;
  logic [GATE_W-1:0] cnt;
  logic              rise;

  always_ff @(posedge clk) begin
    if (rst) sy <= '0;
    else     sy <= {sy[1:0], raw};
  end

  assign rise = sy[1] & ~sy[2];

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (rise)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign gate = (cnt != '0);

  p_gate_open_r1: assert property (@(posedge clk) disable iff (rst)
    (rise && len != '0) |=> gate);
  p_gate_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (len == '0 && !gate) |=> !gate);
endmodule

// File: rtl/ctrg_prescale.sv
module ctrg_prescale
  import ctrg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              coin,
  input  logic              wr,
  input  logic [CODE_W-1:0] wcode,
  output logic              hit
);
  logic [CODE_W-1:0] code_q;
  logic [PCNT_W-1:0] cnt_q;
  logic [PCNT_W-1:0] lim;
  logic              coin_d;
  logic              onset;

  assign lim   = ps_limit(code_q);
  assign onset = coin & ~coin_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      cnt_q  <= '0;
      coin_d <= 1'b0;
      hit    <= 1'b0;
    end else begin
      coin_d <= coin;
      hit    <= 1'b0;
      if (wr) begin
        code_q <= wcode;
        cnt_q  <= '0;
      end else if (onset && code_q != '0) begin
        if (cnt_q == lim) begin
          cnt_q <= '0;
          hit   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (code_q == '0) |=> !hit);
  p_single_r4: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim);
  p_wr_clear_r6: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt_q == '0 && !hit));
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
  import ctrg_pkg::*;
#(
  parameter int GATE_W   = 8,
  parameter int GATE_RST = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   det_in,
  input  logic              sw_trig,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              pat_clr,
  output logic              trig_out,
  output logic              pat_valid,
  output logic [PAT_W-1:0]  pat_word
);
  localparam int GATE_ADDR = N_PS;

  logic [GATE_W-1:0] gate_len;
  logic [N_IN-1:0]   gate;
  logic [N_PS-1:0]   coin;
  logic [N_PS-1:0]   ps_hit;
  logic              fire;

  always_ff @(posedge clk) begin
    if (rst)
      gate_len <= GATE_W'(GATE_RST);
    else if (cfg_we && cfg_addr == ADDR_W'(GATE_ADDR))
      gate_len <= cfg_wdata[GATE_W-1:0];
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    ctrg_stretch #(.GATE_W(GATE_W)) u_st (
      .clk  (clk),
      .rst  (rst),
      .raw  (det_in[i]),
      .len  (gate_len),
      .gate (gate[i])
    );
  end

  always_comb coin = coin_map(gate);

  for (genvar c = 0; c < N_PS; c++) begin : g_ps
    ctrg_prescale u_ps (
      .clk   (clk),
      .rst   (rst),
      .coin  (coin[c]),
      .wr    (cfg_we && cfg_addr == ADDR_W'(c)),
      .wcode (cfg_wdata[CODE_W-1:0]),
      .hit   (ps_hit[c])
    );
  end

  assign fire = ~pat_valid & ((|ps_hit) | sw_trig);

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_out  <= 1'b0;
      pat_valid <= 1'b0;
      pat_word  <= '0;
    end else if (fire) begin
      trig_out  <= 1'b1;
      pat_valid <= 1'b1;
      pat_word  <= pack_pattern(gate, ps_hit, sw_trig);
    end else begin
      trig_out <= 1'b0;
      if (pat_clr) pat_valid <= 1'b0;
    end
  end

  p_trig_valid_r7: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> pat_valid);
  p_trig_once_r7: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (pat_valid && !pat_clr) |=> (pat_valid && $stable(pat_word)));
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (pat_valid && pat_clr) |=> !pat_valid);
endmodule

// File: tb/coinc_trigger_bench.sv
`timescale 1ns/1ps
module coinc_trigger_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  det_in = '0;
  logic        sw_trig = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        pat_clr = 1'b0;
  logic        trig_out;
  logic        pat_valid;
  logic [16:0] pat_word;

  always #2.5 clk = ~clk;

  coinc_trigger u_coinc_trigger (
    .clk(clk), .rst(rst), .det_in(det_in), .sw_trig(sw_trig),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pat_clr(pat_clr), .trig_out(trig_out), .pat_valid(pat_valid),
    .pat_word(pat_word)
  );

  // ---------------- behavioural reference ----------------
  logic [5:0]  m_s1, m_s2, m_s3;
  int          m_gc [6];
  logic        m_cprev [9];
  int          m_code [9];
  int          m_cnt [9];
  logic [8:0]  m_pulse;
  int          m_glen;
  logic        m_valid, m_trig;
  logic [16:0] m_pat;

  function automatic logic m_coin(input logic [5:0] g, input int c);
    case (c)
      0: return g[1];
      1: return g[0];
      2: return g[4] && !g[5];
      3: return g[2] && g[3];
      4: return g[2] && g[4];
      5: return g[2] && g[5];
      6: return g[3] && g[4];
      7: return g[3] && g[5];
      default: return g[4] && g[5];
    endcase
  endfunction

  function automatic logic [16:0] upper_bit(input int c);
    case (c)
      0: return 17'h10000;
      1: return 17'h08000;
      2: return 17'h00040;
      3: return 17'h02000;
      4: return 17'h01000;
      5: return 17'h00800;
      6: return 17'h00400;
      7: return 17'h00200;
      default: return 17'h00180;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [5:0] g;
    logic [16:0] p;
    logic on;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
      for (int i = 0; i < 6; i++) m_gc[i] = 0;
      for (int c = 0; c < 9; c++) begin m_cprev[c] = 0; m_code[c] = 0; m_cnt[c] = 0; end
      m_pulse = '0; m_glen = 4; m_valid = 0; m_trig = 0; m_pat = '0;
    end else begin
      for (int i = 0; i < 6; i++) g[i] = (m_gc[i] != 0);
      if (!m_valid && (sw_trig || m_pulse != '0)) begin
        p = {11'd0, g};
        for (int c = 0; c < 9; c++) if (m_pulse[c]) p = p | upper_bit(c);
        if (sw_trig) p[14] = 1'b1;
        m_pat = p; m_trig = 1; m_valid = 1;
      end else begin
        m_trig = 0;
        if (pat_clr) m_valid = 0;
      end
      for (int c = 0; c < 9; c++) begin
        on = m_coin(g, c) && !m_cprev[c];
        m_pulse[c] = 1'b0;
        if (cfg_we && cfg_addr == 4'(c)) begin
          m_code[c] = int'(cfg_wdata[3:0]); m_cnt[c] = 0;
        end else if (on && m_code[c] != 0) begin
          if (m_cnt[c] == (1 << (m_code[c] - 1)) - 1) begin m_cnt[c] = 0; m_pulse[c] = 1'b1; end
          else m_cnt[c] = m_cnt[c] + 1;
        end
        m_cprev[c] = m_coin(g, c);
      end
      for (int i = 0; i < 6; i++) begin
        if (m_s2[i] && !m_s3[i]) m_gc[i] = m_glen;
        else if (m_gc[i] > 0) m_gc[i] = m_gc[i] - 1;
      end
      if (cfg_we && cfg_addr == 4'd9) m_glen = int'(cfg_wdata);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = det_in;
    end
  end

  // ---------------- checking ----------------
  int checks = 0;
  int errors = 0;
  int n_trig = 0;
  logic [16:0] last_pat = '0;
  logic auto_ack = 1'b1;
  logic timed_out = 1'b0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (!rst) begin
      check(trig_out == m_trig, "R7 trig_out vs model", 32'(trig_out), 32'(m_trig));
      check(pat_valid == m_valid, "R10 pat_valid vs model", 32'(pat_valid), 32'(m_valid));
      check(pat_word[5:0] == m_pat[5:0], "R8 raw bits vs model", 32'(pat_word[5:0]), 32'(m_pat[5:0]));
      check(pat_word[16:6] == m_pat[16:6], "R9 source bits vs model", 32'(pat_word[16:6]), 32'(m_pat[16:6]));
      if (trig_out) begin n_trig++; last_pat = pat_word; end
    end
    pat_clr = auto_ack && pat_valid;
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] m, input int lo);
    det_in = m; tick();
    det_in = '0;
    repeat (lo) tick();
  endtask

  task automatic run();
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R11 reset state
    check(trig_out == 0 && pat_valid == 0 && pat_word == 0, "R11 reset outputs",
          {14'd0, trig_out, pat_valid, pat_word}, 32'd0);
    // R12 out-of-map writes
    wr(12, 1); wr(10, 1); wr(15, 3);
    pulse(6'h3F, 14);
    check(n_trig == 0, "R12 stray address writes", 32'(n_trig), 0);
    // R3 disabled channels
    pulse(6'h01, 12); pulse(6'h3F, 12);
    check(n_trig == 0, "R3 code 0 silent", 32'(n_trig), 0);
    // R4 pass every onset
    wr(1, 1);
    n_trig = 0;
    repeat (3) pulse(6'h01, 12);
    check(n_trig == 3, "R4 code 1 count", 32'(n_trig), 3);
    check(last_pat == 17'h08001, "R4 cosmic pattern", 32'(last_pat), 32'h08001);
    // R5 divide by 4
    wr(1, 3);
    n_trig = 0;
    repeat (8) pulse(6'h01, 12);
    check(n_trig == 2, "R5 code 3 divides by 4", 32'(n_trig), 2);
    // R6 write clears count
    n_trig = 0;
    repeat (3) pulse(6'h01, 12);
    wr(1, 3);
    repeat (3) pulse(6'h01, 12);
    check(n_trig == 0, "R6 count cleared by write", 32'(n_trig), 0);
    pulse(6'h01, 12);
    check(n_trig == 1, "R6 fourth onset after rewrite", 32'(n_trig), 1);
    wr(1, 0);
    // R2 / R8 / R9 each channel alone
    for (int c = 0; c < 9; c++) begin
      logic [5:0] m;
      case (c)
        0: m = 6'h02; 1: m = 6'h01; 2: m = 6'h10; 3: m = 6'h0C; 4: m = 6'h14;
        5: m = 6'h24; 6: m = 6'h18; 7: m = 6'h28; default: m = 6'h30;
      endcase
      wr(c, 1);
      n_trig = 0;
      pulse(m, 12);
      check(n_trig == 1, "R2 channel fires once", 32'(n_trig), 1);
      check(last_pat[16:6] == upper_bit(c) >> 6, "R9 source bit position",
            32'(last_pat[16:6]), 32'(upper_bit(c) >> 6));
      check(last_pat[5:0] == m, "R8 raw gate bits", 32'(last_pat[5:0]), 32'(m));
      wr(c, 0);
    end
    // R1 gate overlap
    wr(3, 1); wr(9, 3);
    n_trig = 0;
    det_in = 6'h04; tick(); det_in = 0; tick(); det_in = 6'h08; tick(); det_in = 0;
    repeat (12) tick();
    check(n_trig == 1, "R1 edges 2 apart overlap at length 3", 32'(n_trig), 1);
    det_in = 6'h04; tick(); det_in = 0; repeat (4) tick(); det_in = 6'h08; tick(); det_in = 0;
    repeat (12) tick();
    check(n_trig == 1, "R1 edges 5 apart miss at length 3", 32'(n_trig), 1);
    wr(9, 0);
    pulse(6'h0C, 12);
    check(n_trig == 1, "R1 length 0 never opens", 32'(n_trig), 1);
    wr(9, 4); wr(3, 0);
    // R7 software trigger
    n_trig = 0;
    sw_trig = 1; tick(); sw_trig = 0; repeat (4) tick();
    check(n_trig == 1 && last_pat == 17'h04000, "R7 software trigger",
          32'(last_pat), 32'h04000);
    // R10 blocking with counters running
    wr(1, 2);
    auto_ack = 0;
    n_trig = 0;
    sw_trig = 1; tick(); sw_trig = 0;
    repeat (3) pulse(6'h01, 12);
    check(n_trig == 1 && pat_valid == 1, "R10 blocked while held",
          32'(n_trig), 1);
    auto_ack = 1; tick(); tick();
    check(pat_valid == 0, "R10 cleared by ack", 32'(pat_valid), 0);
    pulse(6'h01, 12);
    check(n_trig == 2 && last_pat[15] == 1, "R10 count advanced while blocked",
          32'(n_trig), 2);
    // mixed onsets: clock and S0·S1 together with software trigger
    wr(0, 1); wr(3, 1);
    det_in = 6'h0E; sw_trig = 1; tick(); sw_trig = 0; det_in = 0;
    repeat (14) tick();
  endtask

  initial begin
    fork
      run();
      begin repeat (150000) @(posedge clk); timed_out = 1'b1; end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "watchdog expired", 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule